// File: doc/BRIEF.md
# Module Reset and Interrupt Sequencer

This block sits in the management logic of a pluggable module. It watches an active-low module reset pin driven by the host, ignores short glitches on it, and runs a full reset only when the pin has stayed low for a minimum number of clock cycles. A full reset produces a one-cycle soft reset pulse that returns user settings elsewhere in the module to their defaults.

Once the pin is released, an initialization timer runs. While it runs, a not-ready status bit stays set so the host knows that status contents are not yet valid. When the timer expires, the block clears not-ready and drives an active-low interrupt so the host can read the flags. The same completion interrupt is posted after power-up or hot insertion, with no reset pulse needed. A host acknowledge pulse, which stands for the host reading the flag byte, releases the interrupt.

The pin is asynchronous and passes through a two-stage synchronizer. The minimum low length and the initialization time are parameters given in clock cycles.

Top module: `modrst_seq`

## Requirements
- R1: While `rst` is high and on the first sample after it, `irq_n` is 1, `not_ready` is 1 and `soft_rst` is 0.
- R2: After `rst` is released with `mod_rst_n` high, `irq_n` falls and `not_ready` falls together at the INIT_CYC-th rising edge after release. No `soft_rst` pulse is produced.
- R3: If `mod_rst_n` is sampled low on MIN_LOW_CYC or more consecutive rising edges, `soft_rst` is high for exactly one cycle. It rises at the edge MIN_LOW_CYC+1 edges after the first edge that samples the pin low. There is one pulse per low period, however long that period is.
- R4: In the cycle where `soft_rst` is high, `not_ready` is 1 and `irq_n` is 1.
- R5: While initialization is complete, a low period shorter than MIN_LOW_CYC sampled edges has no effect: `not_ready` stays 0, `irq_n` keeps its value, and no `soft_rst` pulse is produced.
- R6: After a qualified reset, `irq_n` falls and `not_ready` falls at the edge INIT_CYC+2 edges after the first edge that samples `mod_rst_n` high again.
- R7: If `mod_rst_n` goes low during initialization, the timer is abandoned and `not_ready` stays 1. Completion is then timed as in R6 from the next release. A short low period here produces no `soft_rst`, while a long one is qualified as in R3.
- R8: When `host_ack` is sampled high while `irq_n` is 0, `irq_n` is 1 from the next edge and `not_ready` stays 0. A `host_ack` during initialization leaves `irq_n` at 1 and does not change the completion time.
- R9: `irq_n` is 0 only while `not_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| mod_rst_n | input | 1 | Asynchronous active-low module reset pin from the host |
| host_ack | input | 1 | One-cycle pulse: host has read the flags, release the interrupt |
| irq_n | output | 1 | Active-low interrupt, registered |
| not_ready | output | 1 | Status bit, 1 while status contents are not valid |
| soft_rst | output | 1 | One-cycle pulse that returns user settings to their defaults |

## Verification
The assertions assume `host_ack` is a synchronous pulse. They also assume `mod_rst_n` holds high while `rst` is asserted, so the power-up timer starts from a released pin. The bench drives every input on the falling clock edge, keeps the pin high through reset, and gives `host_ack` for one cycle only. It spaces its pin pulses so that each expected soft-reset and interrupt event can be placed at an exact cycle: long pulses for qualification, pulses of MIN_LOW_CYC-1 and below for rejection, and pulses placed inside the initialization window to abort it.

// File: rtl/modrst_pkg.sv
package modrst_pkg;
  typedef enum logic [1:0] {
    SQ_INIT = 2'd0,  // timer running, status invalid
    SQ_HOLD = 2'd1,  // pin seen low, waiting for release
    SQ_DONE = 2'd2   // initialization complete
  } seq_state_t;
endpackage

// File: rtl/modrst_sync.sv
module modrst_sync #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= {STAGES{RST_VAL}};
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/modrst_lowqual.sv
module modrst_lowqual #(
  parameter int MIN_LOW_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_s,
  output logic qual
);
  localparam int CW = $clog2(MIN_LOW_CYC + 1);
  localparam logic [CW-1:0] CMAX = CW'(MIN_LOW_CYC);
  localparam logic [CW-1:0] CHIT = CW'(MIN_LOW_CYC - 1);

  logic [CW-1:0] low_cnt;

  // counts synchronized low cycles, saturates so qual fires once per low period
  always_ff @(posedge clk) begin
    if (rst || pin_s)        low_cnt <= '0;
    else if (low_cnt != CMAX) low_cnt <= low_cnt + 1'b1;
  end

  assign qual = !pin_s && (low_cnt == CHIT);
endmodule

// File: rtl/modrst_timer.sv
module modrst_timer #(
  parameter int INIT_CYC = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic hit
);
  localparam int TW = $clog2(INIT_CYC + 1);
  localparam logic [TW-1:0] THIT = TW'(INIT_CYC - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en)    cnt <= cnt + 1'b1;
  end

  assign hit = en && (cnt == THIT);
endmodule

// File: rtl/modrst_seq.sv
module modrst_seq #(
  parameter int MIN_LOW_CYC = 8,
  parameter int INIT_CYC    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mod_rst_n,
  input  logic host_ack,
  output logic irq_n,
  output logic not_ready,
  output logic soft_rst
);
  import modrst_pkg::*;

  seq_state_t state;
  logic pin_s, qual, t_hit, t_clr, t_en;

  modrst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(mod_rst_n), .q(pin_s)
  );

  modrst_lowqual #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_qual (
    .clk(clk), .rst(rst), .pin_s(pin_s), .qual(qual)
  );

  assign t_en  = (state == SQ_INIT) && pin_s;
  assign t_clr = !t_en;

  modrst_timer #(.INIT_CYC(INIT_CYC)) u_timer (
    .clk(clk), .rst(rst), .clr(t_clr), .en(t_en), .hit(t_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_INIT;
      soft_rst  <= 1'b0;
      not_ready <= 1'b1;
      irq_n     <= 1'b1;
    end else begin
      soft_rst <= 1'b0;
      if (qual) begin
        state     <= SQ_HOLD;
        soft_rst  <= 1'b1;
        not_ready <= 1'b1;
        irq_n     <= 1'b1;
      end else begin
        case (state)
          SQ_INIT: begin
            if (!pin_s) state <= SQ_HOLD;
            else if (t_hit) begin
              state     <= SQ_DONE;
              not_ready <= 1'b0;
              irq_n     <= 1'b0;
            end
          end
          SQ_HOLD: if (pin_s) state <= SQ_INIT;
          SQ_DONE: if (host_ack) irq_n <= 1'b1;
          default: state <= SQ_INIT;
        endcase
      end
    end
  end
endmodule

// File: rtl/modrst_seq_chk.sv
module modrst_seq_chk (
  input logic clk,
  input logic rst,
  input logic host_ack,
  input logic irq_n,
  input logic not_ready,
  input logic soft_rst
);
  AST_SOFT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) soft_rst |=> !soft_rst); // R3
  AST_SOFT_CLEARS_STATUS: assert property (@(posedge clk) disable iff (rst) soft_rst |-> (not_ready && irq_n)); // R4
  AST_NR_RISE_ONLY_ON_SOFT: assert property (@(posedge clk) disable iff (rst) $rose(not_ready) |-> soft_rst); // R5
  AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst) $fell(not_ready) |-> !irq_n); // R6
  AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (rst) $fell(irq_n) |-> $fell(not_ready)); // R2
  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (rst) (host_ack && !irq_n) |=> irq_n); // R8
  AST_IRQ_NEEDS_READY: assert property (@(posedge clk) disable iff (rst) !irq_n |-> !not_ready); // R9
endmodule

bind modrst_seq modrst_seq_chk chk_i (
  .clk(clk), .rst(rst), .host_ack(host_ack),
  .irq_n(irq_n), .not_ready(not_ready), .soft_rst(soft_rst)
);

// File: tb/modrst_seq_tb.sv
module modrst_seq_tb_top;
  localparam int MIN = 6;
  localparam int INIT = 20;
  localparam int K_SOFT = 0;
  localparam int K_IRQ = 1;

  typedef struct { int kind; int at; } exp_t;

  logic clk = 1'b0, rst = 1'b1, pin = 1'b1, ack = 1'b0;
  logic irq_n, not_ready, soft_rst;
  int cyc = 0, total = 0, bad = 0;
  logic prev_irq = 1'b1;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  modrst_seq #(.MIN_LOW_CYC(MIN), .INIT_CYC(INIT), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .mod_rst_n(pin), .host_ack(ack),
    .irq_n(irq_n), .not_ready(not_ready), .soft_rst(soft_rst)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // scoreboard monitor: compares observed events with queued expectations
  task automatic observe(input int kind);
    exp_t e;
    if (q.size() == 0) begin
      chk(1'b0, kind == K_SOFT ? "R3/R5/R7 unexpected soft_rst" : "R2/R6 unexpected irq", cyc, -1);
      return;
    end
    e = q.pop_front();
    chk(e.kind == kind, "R3/R6 event kind", kind, e.kind);
    chk(e.at == cyc, kind == K_SOFT ? "R3 soft_rst cycle" : "R6 irq cycle", cyc, e.at);
    if (kind == K_SOFT) chk(not_ready && irq_n, "R4 status on soft_rst", {not_ready, irq_n}, 3);
    else                chk(!not_ready, "R9 not_ready with irq", not_ready, 0);
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (soft_rst) observe(K_SOFT);
      if (prev_irq && !irq_n) observe(K_IRQ);
      prev_irq <= irq_n;
    end
  end

  // driver: one low period on the pin, pushes expected events
  task automatic pulse(input int len, input bit exp_irq);
    int n, m;
    @(negedge clk);
    n = cyc;
    pin = 1'b0;
    if (len >= MIN) q.push_back('{K_SOFT, n + 2 + MIN});
    repeat (len) @(negedge clk);
    m = cyc;
    pin = 1'b1;
    if (exp_irq) q.push_back('{K_IRQ, m + 3 + INIT});
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL all requirements: watchdog actual=%0d expected<%0d", cyc, 20000);
    finish_run();
  end

  initial begin
    int p;
    repeat (5) @(negedge clk);
    chk(irq_n == 1'b1, "R1 irq_n in reset", irq_n, 1);
    chk(not_ready == 1'b1, "R1 not_ready in reset", not_ready, 1);
    chk(soft_rst == 1'b0, "R1 soft_rst in reset", soft_rst, 0);
    p = cyc;
    rst = 1'b0;
    q.push_back('{K_IRQ, p + INIT});  // R2 power-up completion
    @(negedge clk);
    chk(irq_n && not_ready && !soft_rst, "R1 first sample after reset", {irq_n, not_ready, soft_rst}, 6);
    repeat (INIT + 5) @(negedge clk);
    chk(!irq_n && !not_ready, "R2 completed after power-up", {irq_n, not_ready}, 0);

    // R5: short low periods while done, including MIN-1
    pulse(3, 1'b0);
    pulse(MIN - 1, 1'b0);
    repeat (10) @(negedge clk);
    chk(!not_ready, "R5 not_ready after short pulses", not_ready, 0);
    chk(!irq_n, "R5 irq_n after short pulses", irq_n, 0);

    // R8: acknowledge releases interrupt
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    chk(irq_n, "R8 irq_n after ack", irq_n, 1);
    chk(!not_ready, "R8 not_ready after ack", not_ready, 0);

    // R3/R4/R6: exactly MIN cycles low
    pulse(MIN, 1'b1);
    repeat (8) @(negedge clk);
    chk(not_ready, "R6 not_ready during init", not_ready, 1);
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    @(negedge clk);
    chk(irq_n, "R8 ack during init ignored", irq_n, 1);
    repeat (INIT + 5) @(negedge clk);

    // R3: long low period gives one pulse
    pulse(15, 1'b1);
    repeat (INIT + 8) @(negedge clk);

    // R7: short pulse during init aborts the timer, no soft reset
    pulse(10, 1'b0);
    repeat (5) @(negedge clk);
    pulse(3, 1'b1);
    repeat (INIT / 2) @(negedge clk);
    chk(not_ready, "R7 not_ready after abort", not_ready, 1);
    repeat (INIT) @(negedge clk);

    // R7: qualified pulse during init
    pulse(10, 1'b0);
    repeat (5) @(negedge clk);
    pulse(MIN + 2, 1'b1);
    repeat (INIT + 10) @(negedge clk);

    chk(q.size() == 0, "R2/R3/R6/R7 pending expected events", q.size(), 0);
    chk(!irq_n && !not_ready, "R6 final completion", {irq_n, not_ready}, 0);
    finish_run();
  end
endmodule